// File: doc/BRIEF.md
# Priority Reference Selector

This block chooses which of twelve candidate input references a digital PLL tracks. Each candidate arrives with a qualification flag from its frequency and activity monitor and carries a 4-bit priority programmed by software. The block combines the two to pick the best qualified input. A forced mode overrides the choice and pins the selection to one index. Each time the chosen index changes, the block emits a one-clock request so that the downstream phase logic can rebuild its alignment before the loop sees the new clock.

In automatic mode the block can be revertive or non-revertive. In revertive mode it always follows the best qualified candidate. In non-revertive mode it stays on the current input for as long as that input is still usable, and it moves only when that input drops out. When no candidate is usable, a flag reports this and the last selection is kept.

All three outputs are registered. They reflect the inputs that were present at the previous rising clock edge.

Top module: `ref_selector`

## Requirements
- R1: Synchronous reset, while it is held, drives `sel_idx` to 0, `sel_change` to 0 and `no_ref` to 1.
- R2: Input i is eligible only when `ref_valid[i]` is 1 and its priority field `ref_prio[4*i+3:4*i]` is nonzero. A priority of 0 removes the input from automatic choice.
- R3: In revertive automatic mode (`force_en`=0, `revert_en`=1), the eligible input with the numerically smallest priority is selected. On equal priorities the lowest index wins. The outputs update on the clock edge after the inputs are applied.
- R4: In non-revertive automatic mode (`force_en`=0, `revert_en`=0), the current index is kept while it remains eligible, even when a better eligible input exists.
- R5: In non-revertive mode, when the current input stops being eligible, the selection moves to the best eligible input under the ordering of R3.
- R6: In automatic mode with no eligible input, `no_ref` is 1 and `sel_idx` holds its previous value. Otherwise, in automatic mode, `no_ref` is 0.
- R7: With `force_en`=1 and `force_idx` in 0..11, `sel_idx` becomes `force_idx` whether or not that input is valid, and `no_ref` equals the inverse of `ref_valid[force_idx]`.
- R8: With `force_en`=1 and `force_idx` in 12..15, the request is ignored: `sel_idx` holds, and `no_ref` equals the inverse of `ref_valid[sel_idx]`.
- R9: `sel_change` is 1 for exactly the clock in which `sel_idx` takes a value different from the one it held on the previous clock, and 0 otherwise.
- R10: Forced mode takes precedence over `revert_en`. The revertive setting has no effect while `force_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 12 | Per-input qualification from the reference monitors |
| ref_prio | input | 48 | Packed priorities, 4 bits per input, input 0 in the low bits |
| force_en | input | 1 | 1 selects forced mode |
| force_idx | input | 4 | Index requested in forced mode |
| revert_en | input | 1 | 1 selects revertive automatic mode |
| sel_idx | output | 4 | Currently selected input index |
| sel_change | output | 1 | One-clock request for phase re-alignment on each selection change |
| no_ref | output | 1 | No usable reference under the current mode |

## Verification
A one-hot sweep walks a single valid input through every index, which shows that each index can be chosen and that every move raises one change pulse. Directed patterns then separate the ordering rules: equal priorities decide between the tie-break and the scan direction, a zero priority on a valid input shows that priority 0 excludes the input, and adding a better input while on a still-usable one tells revertive behaviour apart from non-revertive. A long pseudo-random walk flips one valid bit at a time, reprograms priorities now and then and mixes the three modes with in-range and out-of-range forced indices. Every cycle of that walk is compared with an arithmetic model, which exposes faults that only show up when the hold and switch decisions interact.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int NUM_REFS = 12;
    localparam int PRIO_W   = 4;
    localparam int IDX_W    = $clog2(NUM_REFS);

    typedef logic [IDX_W-1:0]  ref_idx_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam ref_idx_t LAST_IDX = ref_idx_t'(NUM_REFS - 1);

    typedef enum logic [1:0] {
        MODE_REVERT = 2'd0,
        MODE_STICKY = 2'd1,
        MODE_FORCED = 2'd2
    } sel_mode_e;

    typedef struct packed {
        logic     found;
        ref_idx_t idx;
    } pick_t;

    function automatic sel_mode_e mode_of(input logic force_en, input logic revert_en);
        if (force_en)
            return MODE_FORCED;
        else if (revert_en)
            return MODE_REVERT;
        else
            return MODE_STICKY;
    endfunction

endpackage

// File: rtl/refsel_qual.sv
module refsel_qual
    import refsel_pkg::*;
(
    input  logic [NUM_REFS-1:0]        ref_valid,
    input  logic [NUM_REFS*PRIO_W-1:0] prio_flat,
    output prio_t [NUM_REFS-1:0]       prio_arr,
    output logic [NUM_REFS-1:0]        eligible
);

    // Unpack priorities and qualify each candidate (R2)
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
        assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
        assign eligible[g] = ref_valid[g] && (prio_arr[g] != '0);
    end

endmodule

// File: rtl/refsel_rank.sv
module refsel_rank
    import refsel_pkg::*;
(
    input  prio_t [NUM_REFS-1:0] prio_arr,
    input  logic [NUM_REFS-1:0]  eligible,
    output pick_t                best
);

    prio_t best_p;

    // Scan upward. The strict compare keeps the lowest index on equal priority (R3)
    always_comb begin
        best   = '0;
        best_p = '1;
        for (int i = 0; i < NUM_REFS; i++) begin
            if (eligible[i] && (!best.found || (prio_arr[i] < best_p))) begin
                best.found = 1'b1;
                best.idx   = ref_idx_t'(i);
                best_p     = prio_arr[i];
            end
        end
    end

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REFS-1:0] ref_valid,
    input  logic [NUM_REFS-1:0] eligible,
    input  pick_t               best,
    input  logic                force_en,
    input  ref_idx_t            force_idx,
    input  logic                revert_en,
    output ref_idx_t            sel_idx,
    output logic                sel_change,
    output logic                no_ref
);

    sel_mode_e mode;
    ref_idx_t  nxt_idx;
    logic      nxt_none;

    always_comb begin
        mode     = mode_of(force_en, revert_en);
        nxt_idx  = sel_idx;
        nxt_none = 1'b1;
        unique case (mode)
            MODE_FORCED: begin
                if (force_idx <= LAST_IDX) begin
                    nxt_idx  = force_idx;
                    nxt_none = !ref_valid[force_idx];
                end else begin
                    nxt_none = !ref_valid[sel_idx];
                end
            end
            MODE_STICKY: begin
                if (eligible[sel_idx]) begin
                    nxt_none = 1'b0;
                end else if (best.found) begin
                    nxt_idx  = best.idx;
                    nxt_none = 1'b0;
                end
            end
            default: begin
                if (best.found) begin
                    nxt_idx  = best.idx;
                    nxt_none = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_idx    <= '0;
            sel_change <= 1'b0;
            no_ref     <= 1'b1;
        end else begin
            sel_idx    <= nxt_idx;
            sel_change <= (nxt_idx != sel_idx);
            no_ref     <= nxt_none;
        end
    end

    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        sel_idx <= LAST_IDX);

    assert_winner_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        best.found |-> eligible[best.idx]);

    assert_pulse_on_move_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sel_idx != $past(sel_idx))) |-> sel_change);

    assert_pulse_only_on_move_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sel_change) |-> (sel_idx != $past(sel_idx)));

    assert_forced_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(force_en) && ($past(force_idx) <= LAST_IDX))
            |-> (sel_idx == $past(force_idx)));

    assert_sticky_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(force_en) && !$past(revert_en) && $past(eligible[sel_idx]))
            |-> $stable(sel_idx));

    assert_none_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(force_en) && no_ref) |-> $stable(sel_idx));

endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import refsel_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_REFS-1:0]         ref_valid,
    input  logic [NUM_REFS*PRIO_W-1:0]  ref_prio,
    input  logic                        force_en,
    input  logic [IDX_W-1:0]            force_idx,
    input  logic                        revert_en,
    output logic [IDX_W-1:0]            sel_idx,
    output logic                        sel_change,
    output logic                        no_ref
);

    prio_t [NUM_REFS-1:0] prio_arr;
    logic  [NUM_REFS-1:0] eligible;
    pick_t                best;

    refsel_qual u_qual (
        .ref_valid (ref_valid),
        .prio_flat (ref_prio),
        .prio_arr  (prio_arr),
        .eligible  (eligible)
    );

    refsel_rank u_rank (
        .prio_arr (prio_arr),
        .eligible (eligible),
        .best     (best)
    );

    refsel_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ref_valid  (ref_valid),
        .eligible   (eligible),
        .best       (best),
        .force_en   (force_en),
        .force_idx  (force_idx),
        .revert_en  (revert_en),
        .sel_idx    (sel_idx),
        .sel_change (sel_change),
        .no_ref     (no_ref)
    );

endmodule

// File: tb/sim_ref_selector.sv
`timescale 1ns/1ps
module sim_ref_selector;

    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  ref_valid = '0;
    logic [4*N-1:0] ref_prio = '0;
    logic          force_en = 1'b0;
    logic [3:0]    force_idx = '0;
    logic          revert_en = 1'b1;
    logic [3:0]    sel_idx;
    logic          sel_change;
    logic          no_ref;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_idx = 0;
    int exp_chg = 0;
    int exp_nr  = 1;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    ref_selector u0 (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_prio(ref_prio),
        .force_en(force_en), .force_idx(force_idx), .revert_en(revert_en),
        .sel_idx(sel_idx), .sel_change(sel_change), .no_ref(no_ref)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int prio_of(input int i);
        return int'(ref_prio[4*i +: 4]);
    endfunction

    function automatic bit elig(input int i);
        return ref_valid[i] && (prio_of(i) != 0);
    endfunction

    // Best candidate by requirement R3 ordering, -1 when none
    function automatic int best_of();
        int b = -1;
        for (int i = 0; i < N; i++)
            if (elig(i) && (b < 0 || prio_of(i) < prio_of(b))) b = i;
        return b;
    endfunction

    // Advance the expected state from the currently applied inputs
    task automatic model_step();
        int nx = exp_idx;
        int nr = 1;
        int b  = best_of();
        if (force_en) begin
            if (force_idx < 4'd12) begin
                nx = int'(force_idx);
                nr = ref_valid[force_idx] ? 0 : 1;
            end else begin
                nr = ref_valid[exp_idx] ? 0 : 1;
            end
        end else if (!revert_en && elig(exp_idx)) begin
            nr = 0;
        end else if (b >= 0) begin
            nx = b;
            nr = 0;
        end
        exp_chg = (nx != exp_idx) ? 1 : 0;
        exp_idx = nx;
        exp_nr  = nr;
    endtask

    // Inputs are already set at a falling edge; clock once, then compare
    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " sel_idx"},    int'(sel_idx),    exp_idx);
        chk({tag, " sel_change"}, int'(sel_change), exp_chg);
        chk({tag, " no_ref"},     int'(no_ref),     exp_nr);
    endtask

    task automatic set_all_prio(input logic [3:0] p);
        for (int i = 0; i < N; i++) ref_prio[4*i +: 4] = p;
    endtask

    function automatic logic [31:0] nxt_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset sel_idx", int'(sel_idx), 0);
        chk("R1 reset sel_change", int'(sel_change), 0);
        chk("R1 reset no_ref", int'(no_ref), 1);
        rst = 1'b0;

        // R6: nothing valid after reset
        step("R6 empty");

        // R2/R3/R9: one-hot walk over every index
        set_all_prio(4'd5);
        for (int i = 0; i < N; i++) begin
            ref_valid = '0;
            ref_valid[i] = 1'b1;
            step("R3 onehot");
            step("R9 settle");
        end

        // R3 tie: inputs 4 and 9 equal, 7 worse
        ref_valid = '0;
        ref_valid[4] = 1; ref_valid[9] = 1; ref_valid[7] = 1;
        set_all_prio(4'd6);
        ref_prio[4*7 +: 4] = 4'd9;
        step("R3 tie");
        chk("R3 tie lowest index", int'(sel_idx), 4);

        // R2: valid but priority 0 is excluded
        ref_prio[4*4 +: 4] = 4'd0;
        step("R2 prio zero");
        chk("R2 prio zero skip", int'(sel_idx), 9);

        // R4: non-revertive keeps 9 when 2 arrives with better priority
        revert_en = 1'b0;
        ref_valid[2] = 1; ref_prio[4*2 +: 4] = 4'd1;
        step("R4 sticky");
        chk("R4 sticky keep", int'(sel_idx), 9);
        step("R4 sticky again");

        // R5: current drops out
        ref_valid[9] = 1'b0;
        step("R5 failover");
        chk("R5 failover target", int'(sel_idx), 2);

        // R6: everything gone, index held
        ref_valid = '0;
        step("R6 none");
        chk("R6 hold", int'(sel_idx), 2);
        chk("R6 flag", int'(no_ref), 1);

        // R7: forced onto an invalid input
        force_en = 1'b1; force_idx = 4'd11;
        step("R7 forced invalid");
        chk("R7 forced target", int'(sel_idx), 11);
        ref_valid[11] = 1'b1;
        step("R7 forced valid");
        chk("R7 forced flag", int'(no_ref), 0);

        // R8: out-of-range force request ignored
        force_idx = 4'd14;
        ref_valid[0] = 1; ref_prio[4*0 +: 4] = 4'd1;
        step("R8 out of range");
        chk("R8 hold", int'(sel_idx), 11);

        // R10: revertive setting irrelevant under force
        revert_en = 1'b1; force_idx = 4'd3;
        step("R10 force over revert");
        chk("R10 forced", int'(sel_idx), 3);
        force_en = 1'b0;
        step("R3 revert after force");
        chk("R3 revert best", int'(sel_idx), 0);

        // Pseudo-random walk against the model (R3 R4 R5 R6 R7 R8 R9 R10)
        for (int k = 0; k < 3000; k++) begin
            rng = nxt_rng(rng);
            ref_valid[int'(rng[11:8]) % N] ^= 1'b1;
            if (rng[15:12] == 4'd0)
                ref_prio[4*(int'(rng[19:16]) % N) +: 4] = rng[23:20];
            force_en  = (rng[25:24] == 2'b11);
            force_idx = rng[29:26];
            if (rng[31:30] == 2'b00) revert_en = ~revert_en;
            step("R9 random walk");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule